// File: doc/BRIEF.md
# Queue Slot Allocator

This block chooses which slot of an out-of-order queue receives the next entry. It keeps one occupancy bit per slot and reads a mask from firmware that takes slots out of service. A slot is eligible when it is vacant and enabled. Each cycle a request is present, the block grants at most one eligible slot. A selector input picks which of three orders is used to choose that slot.

Slots are released from outside through a multi-bit release vector. Any number of slots can be freed in one cycle. Firmware uses the disable mask to cap the usable depth, or to push back on the producer by making the queue look full. Storing entry data and tracking the later life of each entry are left to neighbouring logic.

Top module: `slot_alloc`

## Requirements
- R1: With `policy` = 0 or 3, the grant goes to the lowest-indexed eligible slot. A slot is eligible when it is vacant and its `dis_mask` bit is 0.
- R2: With `policy` = 1, the search starts at the slot after the last granted slot and wraps from DEPTH-1 to 0. The first eligible slot found is granted.
- R3: With `policy` = 2, the grant goes to the most recently freed slot if that slot is still eligible. Otherwise the lowest-indexed eligible slot is granted. When several occupied slots are freed in one cycle, the highest-indexed of them is recorded as most recently freed.
- R4: `grant` is all zeros and `grant_idx` is 0 when `alloc_req` is low or when no slot is eligible.
- R5: `grant` has at most one bit set, bit i standing for slot i. When a bit is set, `grant_idx` is its index, and that slot is occupied from the next clock.
- R6: A slot whose `dis_mask` bit is 1 is never granted. A slot that is disabled while occupied stays occupied until it is released.
- R7: Every slot set in `release_vec` is vacant after the next clock. A slot released in a cycle cannot be granted in that same cycle.
- R8: `full` is 1 when every enabled slot is occupied. `empty` is 1 when no slot is occupied.
- R9: After reset, all slots are vacant. The rotating pointer sits at slot DEPTH-1, so the first rotating grant goes to slot 0. No slot is recorded as recently freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_req | input | 1 | Request for a slot this cycle |
| release_vec | input | DEPTH | Slots freed this cycle |
| dis_mask | input | DEPTH | Slots removed from service by firmware |
| policy | input | 2 | Allocation order: 0 lowest, 1 rotating, 2 recently freed, 3 lowest |
| grant | output | DEPTH | One-hot slot granted this cycle |
| grant_idx | output | $clog2(DEPTH) | Index of the granted slot |
| full | output | 1 | Every enabled slot is occupied |
| empty | output | 1 | No slot is occupied |

## Verification
Release and allocation can fall in the same cycle. The critical case is a slot freed just as a request arrives, which must not be handed out until the following cycle. The bench provokes this in two ways. A directed sequence frees an occupied slot while requesting with the recently-freed order. Random cycles also free subsets of occupied slots while a request is present. A bench model judges each case by comparing the grant and the flags in that cycle, then the grant in the next cycle, where the freed slot becomes a legal pick.

// File: rtl/slot_alloc.sv
module slot_alloc #(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_req,
  input  logic [DEPTH-1:0]         release_vec,
  input  logic [DEPTH-1:0]         dis_mask,
  input  logic [1:0]               policy,
  output logic [DEPTH-1:0]         grant,
  output logic [$clog2(DEPTH)-1:0] grant_idx,
  output logic                     full,
  output logic                     empty
);
  localparam int IW = $clog2(DEPTH);

  logic [DEPTH-1:0] occ, elig, rel_eff;
  logic [IW-1:0]    rot_ptr, rf_ptr, low_idx, rot_idx, sel_idx, rel_hi;
  logic             rf_vld, granting;

  assign elig     = ~occ & ~dis_mask;
  assign rel_eff  = release_vec & occ;
  assign granting = alloc_req & (|elig);
  assign full     = &(occ | dis_mask);
  assign empty    = ~|occ;

  always_comb begin
    low_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (elig[i]) low_idx = IW'(i);
  end

  always_comb begin
    logic found;
    found   = 1'b0;
    rot_idx = '0;
    for (int k = 1; k <= DEPTH; k++) begin
      int j;
      j = (int'(rot_ptr) + k) % DEPTH;
      if (!found && elig[j]) begin
        rot_idx = IW'(j);
        found   = 1'b1;
      end
    end
  end

  always_comb begin
    case (policy)
      2'd1:    sel_idx = rot_idx;
      2'd2:    sel_idx = (rf_vld && elig[rf_ptr]) ? rf_ptr : low_idx;
      default: sel_idx = low_idx;
    endcase
  end

  assign grant     = granting ? (DEPTH'(1) << sel_idx) : '0;
  assign grant_idx = granting ? sel_idx : '0;

  always_comb begin
    rel_hi = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rel_eff[i]) rel_hi = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ     <= '0;
      rot_ptr <= IW'(DEPTH - 1);
      rf_ptr  <= '0;
      rf_vld  <= 1'b0;
    end else begin
      occ <= (occ & ~release_vec) | grant;
      if (granting) rot_ptr <= sel_idx;
      if (|rel_eff) begin
        rf_ptr <= rel_hi;
        rf_vld <= 1'b1;
      end
    end
  end

  // R5
  onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R6
  no_disabled_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & dis_mask) == '0);

  // R4
  idle_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_req || full) |-> grant == '0);

  // R5
  no_regrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (grant & $past(grant)) == '0);

  // R8
  flags_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && full) |-> (&dis_mask));
endmodule

// File: tb/slot_alloc_test.sv
module slot_alloc_test;
  localparam int D  = 8;
  localparam int IW = $clog2(D);

  logic clk = 0, rst_n = 0;
  logic alloc_req = 0;
  logic [D-1:0] release_vec = '0, dis_mask = '0;
  logic [1:0] policy = 0;
  logic [D-1:0] grant;
  logic [IW-1:0] grant_idx;
  logic full, empty;

  int checks = 0, errors = 0;
  logic [D-1:0] m_occ;
  int m_rot, m_rf;
  logic [D-1:0] last_g;

  always #4 clk = ~clk;

  slot_alloc #(.DEPTH(D)) uut (.clk(clk), .rst_n(rst_n), .alloc_req(alloc_req),
    .release_vec(release_vec), .dis_mask(dis_mask), .policy(policy),
    .grant(grant), .grant_idx(grant_idx), .full(full), .empty(empty));

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lowest(logic [D-1:0] el);
    for (int i = 0; i < D; i++) if (el[i]) return i;
    return -1;
  endfunction

  function automatic int pick(bit rq, logic [D-1:0] ds, logic [1:0] pl);
    logic [D-1:0] el = ~m_occ & ~ds;
    if (!rq || el == '0) return -1;
    if (pl == 1) begin
      for (int k = 1; k <= D; k++) if (el[(m_rot + k) % D]) return (m_rot + k) % D;
    end
    if (pl == 2 && m_rf >= 0 && el[m_rf]) return m_rf;
    return lowest(el);
  endfunction

  task automatic step(bit rq, logic [D-1:0] rl, logic [D-1:0] ds, logic [1:0] pl);
    int e;
    logic [D-1:0] eg, relf;
    string tg;
    @(negedge clk);
    alloc_req = rq; release_vec = rl; dis_mask = ds; policy = pl;
    #1;
    e  = pick(rq, ds, pl);
    eg = (e < 0) ? '0 : (D'(1) << e);
    tg = (e < 0) ? "R4" : (pl == 1) ? "R2" : (pl == 2) ? "R3" : "R1";
    chk(grant == eg, tg, grant, eg);
    chk(grant_idx == ((e < 0) ? 0 : e), "R5", grant_idx, (e < 0) ? 0 : e);
    chk(full == (&(m_occ | ds)), "R8 full", full, &(m_occ | ds));
    chk(empty == (m_occ == '0), "R8 empty", empty, m_occ == '0);
    last_g = grant;
    @(posedge clk);
    relf  = rl & m_occ;
    m_occ = (m_occ & ~rl) | eg;
    if (e >= 0) m_rot = e;
    for (int i = 0; i < D; i++) if (relf[i]) m_rf = i;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_occ = '0; m_rot = D - 1; m_rf = -1;
    repeat (3) @(posedge clk);
    #1;
    chk(grant == '0 && empty && !full, "R9 reset flags", {grant, empty, full}, 2);
    @(negedge clk); rst_n = 1;

    // R9: rotating order starts at slot 0
    step(1, '0, '0, 1);
    chk(last_g == 8'h01, "R9 first rotating grant", last_g, 8'h01);
    step(1, '0, '0, 0);
    step(1, '0, '0, 0);
    // R7: release slot 0 while requesting, must not get slot 0
    step(1, 8'h01, '0, 2);
    chk(last_g == 8'h08, "R7 same-cycle release", last_g, 8'h08);
    // R3: next cycle slot 0 is the recently freed pick
    step(1, '0, '0, 2);
    chk(last_g == 8'h01, "R3 recently freed", last_g, 8'h01);
    // R3: multiple freed -> highest recorded
    step(0, 8'h06, '0, 2);
    step(1, '0, '0, 2);
    chk(last_g == 8'h04, "R3 highest of several", last_g, 8'h04);
    // R6: disable occupied slot 2, fill rest
    for (int i = 0; i < 6; i++) step(1, '0, 8'h04, 0);
    chk(full == 1, "R6 full with disabled occupied", full, 1);
    step(1, 8'h04, 8'h04, 0);
    step(1, '0, 8'h04, 0);
    chk(last_g == '0 && full, "R6 disabled vacant not granted", last_g, 0);
    step(1, '0, '0, 0);
    chk(last_g == 8'h04, "R6 re-enabled granted", last_g, 8'h04);
    // R7: release everything
    step(0, 8'hFF, '0, 0);
    step(0, '0, '0, 0);
    chk(empty == 1, "R7 all released", empty, 1);
    // R2: rotation wrap
    for (int i = 0; i < 10; i++) step(1, (i % 3 == 2) ? m_occ : '0, '0, 1);

    for (int n = 0; n < 4000; n++) begin
      logic [D-1:0] rl, ds;
      rl = ($urandom % 3 == 0) ? (D'($urandom) & m_occ) : '0;
      ds = ($urandom % 8 == 0) ? D'($urandom & $urandom) : dis_mask;
      step($urandom % 4 != 0, rl, ds, 2'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule